// File: doc/BRIEF.md
# Counter-Mode Keystream Wrapper

This block turns any 128-bit block cipher with a request/response handshake into a counter-mode stream engine. It owns a 128-bit counter. Every data block accepted on the input side launches one cipher request that carries the current counter value, and the counter then steps by one. The data block itself waits in a small in-order store. When the cipher answers, the answer is combined by XOR with the oldest waiting data block and handed out. The same operation serves both encryption and decryption.

The cipher may take any number of cycles per request but must answer in request order. A new starting counter is handed in over a separate load handshake. A load that arrives while blocks are still in flight is held. Input is refused until every outstanding block has left, and only then does the new value replace the counter. Keys and the cipher core live outside this block.

Top module: `ctr_stream_xor`

## Requirements
- R1: After reset the counter reads zero on `ciph_req_blk`, `load_ready` is 1 and no block is outstanding.
- R2: An input block is accepted exactly when `in_valid` and `in_ready` are both 1. In that cycle `ciph_req_valid` is 1 and `ciph_req_blk` carries the counter value assigned to that block.
- R3: Each accepted block advances the counter by one, so consecutive blocks use start, start+1, start+2 and so on. The counter is a big-endian integer: `ciph_req_blk[127]` is its most significant bit and `ciph_req_blk[0]` its least significant bit.
- R4: A carry out of the low 64 bits (bits 63:0) increments the high 64 bits (bits 127:64).
- R5: Advancing the all-ones counter gives zero.
- R6: `out_valid` follows `ciph_rsp_valid` and `ciph_rsp_ready` follows `out_ready`. Each output block is the cipher response XOR the input block of the same request, in acceptance order.
- R7: At most FIFO_DEPTH blocks are outstanding. While that many are waiting, `in_ready` is 0.
- R8: A load is accepted when `load_valid` and `load_ready` are both 1. `load_ready` then stays 0 and `in_ready` stays 0 until all outstanding blocks have been delivered. Only then does the loaded value become the counter. A block accepted in the same cycle as the load uses the old counter.
- R9: While idle the counter is visible on `ciph_req_blk` and does not change. After N blocks from start value S it reads S+N modulo 2^128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | New start counter offered |
| load_ready | output | 1 | No load pending; a load can be taken |
| load_ctr | input | 128 | Start counter value, big-endian |
| in_valid | input | 1 | Input data block offered |
| in_ready | output | 1 | Input data block can be taken |
| in_data | input | 128 | Input data block |
| out_valid | output | 1 | Output block available |
| out_ready | input | 1 | Consumer takes the output block |
| out_data | output | 128 | Cipher response XOR matching input block |
| ciph_req_valid | output | 1 | Cipher request offered |
| ciph_req_ready | input | 1 | Cipher can take a request |
| ciph_req_blk | output | 128 | Counter value sent to the cipher |
| ciph_rsp_valid | input | 1 | Cipher response available |
| ciph_rsp_ready | output | 1 | Block takes the cipher response |
| ciph_rsp_blk | input | 128 | Cipher output for the oldest request |

## Verification
The bench builds the block with FIFO_DEPTH of 4 and SEG_W of 64. The shallow store fills after four accepted blocks, so the full-store stall and a load held behind in-flight blocks both occur within a few cycles of a stalled cipher. With 64-bit segments the carry boundary lies exactly at the half split. Start values just below that boundary, and the all-ones value, therefore exercise the carry path and the wrap.

// File: rtl/ctr_stream_pkg.sv
package ctr_stream_pkg;
  localparam int unsigned CS_BLK_W = 128;
  typedef logic [CS_BLK_W-1:0] cs_blk_t;
endpackage

// File: rtl/cs_seg_inc.sv
// Segmented +1: each segment adds the carry rippled from the one below.
module cs_seg_inc #(
  parameter int unsigned W     = 128,
  parameter int unsigned SEG_W = 64
) (
  input  logic [W-1:0] val_i,
  input  logic         inc_i,
  output logic [W-1:0] sum_o
);
  localparam int unsigned NSEG = W / SEG_W;

  logic [NSEG-1:0] carry;

  assign carry[0] = inc_i;

  generate
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
      assign sum_o[g*SEG_W +: SEG_W] =
        val_i[g*SEG_W +: SEG_W] + {{(SEG_W-1){1'b0}}, carry[g]};
      if (g < NSEG - 1) begin : g_carry
        assign carry[g+1] = carry[g] & (&val_i[g*SEG_W +: SEG_W]);
      end
    end
  endgenerate
endmodule

// File: rtl/cs_data_fifo.sv
// In-order store for data blocks waiting on their cipher response.
module cs_data_fifo #(
  parameter int unsigned W     = 128,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_i) begin
      wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
    end
    if (pop_i) begin
      rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
    end
    if (push_i && !pop_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else if (!push_i && pop_i) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      mem_q[wr_q] <= din_i;
    end
  end

  assign dout_o  = mem_q[rd_q];
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign count_o = cnt_q;
endmodule

// File: rtl/cs_ctr_unit.sv
// Counter register with a held load that is applied once the pipe is empty.
module cs_ctr_unit #(
  parameter int unsigned W     = 128,
  parameter int unsigned SEG_W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic         ld_fire_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         drained_i,
  output logic [W-1:0] ctr_o,
  output logic         pend_o
);
  logic [W-1:0] ctr_q, ctr_d, ctr_inc;
  logic [W-1:0] hold_q, hold_d;
  logic         pend_q, pend_d;
  logic         apply;

  cs_seg_inc #(.W(W), .SEG_W(SEG_W)) u_inc (
    .val_i (ctr_q),
    .inc_i (1'b1),
    .sum_o (ctr_inc)
  );

  assign apply = pend_q && drained_i;

  always_comb begin
    ctr_d  = ctr_q;
    hold_d = hold_q;
    pend_d = pend_q;
    if (apply) begin
      ctr_d  = hold_q;
      pend_d = 1'b0;
    end else if (adv_i) begin
      ctr_d = ctr_inc;
    end
    if (ld_fire_i) begin
      hold_d = ld_val_i;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q  <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      ctr_q  <= ctr_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
    end
  end

  assign ctr_o  = ctr_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/ctr_stream_xor.sv
module ctr_stream_xor
  import ctr_stream_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned SEG_W      = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_valid,
  output logic    load_ready,
  input  cs_blk_t load_ctr,
  input  logic    in_valid,
  output logic    in_ready,
  input  cs_blk_t in_data,
  output logic    out_valid,
  input  logic    out_ready,
  output cs_blk_t out_data,
  output logic    ciph_req_valid,
  input  logic    ciph_req_ready,
  output cs_blk_t ciph_req_blk,
  input  logic    ciph_rsp_valid,
  output logic    ciph_rsp_ready,
  input  cs_blk_t ciph_rsp_blk
);
  localparam int unsigned BLK_W = CS_BLK_W;
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             fifo_full;
  logic [CNT_W-1:0] fifo_cnt;
  cs_blk_t          fifo_head;
  logic             pend;
  logic             take_ok;
  logic             in_fire;
  logic             rsp_fire;
  logic             ld_fire;
  cs_blk_t          ctr;

  assign take_ok        = !fifo_full && !pend;
  assign ciph_req_valid = in_valid && take_ok;
  assign in_ready       = ciph_req_ready && take_ok;
  assign in_fire        = in_valid && in_ready;
  assign ciph_req_blk   = ctr;

  assign out_valid      = ciph_rsp_valid;
  assign ciph_rsp_ready = out_ready;
  assign rsp_fire       = ciph_rsp_valid && out_ready;
  assign out_data       = ciph_rsp_blk ^ fifo_head;

  assign load_ready     = !pend;
  assign ld_fire        = load_valid && !pend;

  cs_ctr_unit #(.W(BLK_W), .SEG_W(SEG_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_i     (in_fire),
    .ld_fire_i (ld_fire),
    .ld_val_i  (load_ctr),
    .drained_i (fifo_cnt == '0),
    .ctr_o     (ctr),
    .pend_o    (pend)
  );

  cs_data_fifo #(.W(BLK_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (in_fire),
    .din_i   (in_data),
    .pop_i   (rsp_fire),
    .dout_o  (fifo_head),
    .full_o  (fifo_full),
    .count_o (fifo_cnt)
  );
endmodule

// File: rtl/ctr_stream_xor_chk.sv
module ctr_stream_xor_chk #(
  parameter int unsigned BLK_W = 128,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [BLK_W-1:0] ciph_req_blk,
  input logic             load_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CNT_W-1:0] occ
);
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ciph_req_blk == $past(ciph_req_blk) + BLK_W'(1));

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && load_ready) |=> $stable(ciph_req_blk));

  a_r8_apply_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_ready) |-> occ == '0);

  a_r8_hold_input: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ready && occ != '0) |-> !in_ready);

  a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH)) |-> !in_ready);

  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  a_r6_rsp_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> occ != '0);
endmodule

bind ctr_stream_xor ctr_stream_xor_chk #(
  .BLK_W (BLK_W),
  .DEPTH (FIFO_DEPTH),
  .CNT_W (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .ciph_req_blk (ciph_req_blk),
  .load_ready   (load_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .occ          (fifo_cnt)
);

// File: tb/ctr_stream_xor_test.sv
`timescale 1ns/100ps
module ctr_stream_xor_test;
  localparam int unsigned DEPTH = 4;

  typedef struct packed {
    logic [127:0] iv;
    logic [127:0] fin;
    logic [31:0]  n;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{128'h0, 128'h3, 32'd3},
    '{128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFE,
      128'h0000_0000_0000_0001_0000_0000_0000_0002, 32'd4},
    '{{128{1'b1}}, 128'h1, 32'd2},
    '{128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
      128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3215, 32'd5},
    '{128'h0000_0000_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
      128'h0000_0001_0000_0000_0000_0000_0000_0000, 32'd1},
    '{128'h8000_0000_0000_0000_7FFF_FFFF_FFFF_FFFF,
      128'h8000_0000_0000_0000_8000_0000_0000_0005, 32'd6}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_valid, load_ready;
  logic [127:0] load_ctr;
  logic         in_valid, in_ready;
  logic [127:0] in_data;
  logic         out_valid, out_ready;
  logic [127:0] out_data;
  logic         ciph_req_valid, ciph_req_ready;
  logic [127:0] ciph_req_blk;
  logic         ciph_rsp_valid, ciph_rsp_ready;
  logic [127:0] ciph_rsp_blk;

  always #2.5 clk = ~clk;

  ctr_stream_xor #(.FIFO_DEPTH(DEPTH), .SEG_W(64)) uut (
    .clk(clk), .rst_n(rst_n),
    .load_valid(load_valid), .load_ready(load_ready), .load_ctr(load_ctr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .ciph_req_valid(ciph_req_valid), .ciph_req_ready(ciph_req_ready),
    .ciph_req_blk(ciph_req_blk),
    .ciph_rsp_valid(ciph_rsp_valid), .ciph_rsp_ready(ciph_rsp_ready),
    .ciph_rsp_blk(ciph_rsp_blk)
  );

  int           nchk = 0;
  int           nfail = 0;
  int           cyc = 0;
  int           delay = 0;
  bit           rsp_stall = 0;
  bit           req_stall = 0;
  bit           slow = 0;
  bit           last_in = 0;
  bit           last_ld = 0;
  bit           done = 0;
  logic [127:0] model_ctr = '0;
  logic [127:0] exp_q [$];
  logic [127:0] ciph_q [$];

  function automatic logic [127:0] fcip(input logic [127:0] x);
    return {x[114:0], x[127:115]} ^ 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: observe handshakes before the edge, update cipher model after it.
  task automatic cycle();
    bit in_f, rsp_f, ld_f;
    #1;
    in_f  = in_valid && in_ready;
    rsp_f = ciph_rsp_valid && ciph_rsp_ready;
    ld_f  = load_valid && load_ready;
    if (rsp_f) begin
      if (exp_q.size() == 0) begin
        chk("R6 unexpected output", out_data, '0);
      end else begin
        chk("R6 output block", out_data, exp_q.pop_front());
        void'(ciph_q.pop_front());
      end
      delay = slow ? 5 : (cyc % 3);
    end
    if (in_f) begin
      chk("R2 request valid", 128'(ciph_req_valid), 128'h1);
      chk("R2 request counter", ciph_req_blk, model_ctr);
      exp_q.push_back(fcip(model_ctr) ^ in_data);
      ciph_q.push_back(ciph_req_blk);
      model_ctr = model_ctr + 128'h1;
    end
    if (ld_f) model_ctr = load_ctr;
    last_in = in_f;
    last_ld = ld_f;
    @(posedge clk);
    #1;
    cyc++;
    ciph_req_ready = !(req_stall || (cyc % 7 == 3));
    if (ciph_q.size() > 0 && !rsp_stall) begin
      if (delay == 0) begin
        ciph_rsp_valid = 1'b1;
        ciph_rsp_blk   = fcip(ciph_q[0]);
      end else begin
        delay--;
        ciph_rsp_valid = 1'b0;
      end
    end else begin
      ciph_rsp_valid = 1'b0;
    end
  endtask

  task automatic do_load(input logic [127:0] v);
    load_valid = 1'b1;
    load_ctr   = v;
    cycle();
    while (!last_ld) cycle();
    load_valid = 1'b0;
  endtask

  task automatic drain();
    in_valid  = 1'b0;
    out_ready = 1'b1;
    while (exp_q.size() > 0 || !load_ready) cycle();
    cycle();
  endtask

  task automatic run_batch(input int n, input int base);
    int sent = 0;
    while (sent < n || exp_q.size() > 0) begin
      in_valid  = (sent < n);
      in_data   = {32'(base), 32'(sent), 64'hF0E1_D2C3_B4A5_9687 ^ 64'(sent * 3)};
      out_ready = (cyc % 4 != 2);
      cycle();
      if (last_in) sent++;
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [127:0] held;
    rst_n = 1'b0;
    load_valid = 1'b0; load_ctr = '0;
    in_valid = 1'b0; in_data = '0;
    out_ready = 1'b1;
    ciph_req_ready = 1'b1;
    ciph_rsp_valid = 1'b0; ciph_rsp_blk = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 counter after reset", ciph_req_blk, '0);
    chk("R1 load_ready after reset", 128'(load_ready), 128'h1);
    chk("R1 out_valid after reset", 128'(out_valid), 128'h0);
    chk("R1 in_ready after reset", 128'(in_ready), 128'h1);

    // Vector table: load, stream, compare final counter (R3 R4 R5 R9)
    for (int i = 0; i < 6; i++) begin
      do_load(VECS[i].iv);
      drain();
      chk("R8 loaded value visible", ciph_req_blk, VECS[i].iv);
      run_batch(int'(VECS[i].n), i);
      cycle();
      if (i == 1 || i == 4)
        chk("R9 R4 final counter with carry", ciph_req_blk, VECS[i].fin);
      else if (i == 2)
        chk("R9 R5 final counter after wrap", ciph_req_blk, VECS[i].fin);
      else
        chk("R9 R3 final counter", ciph_req_blk, VECS[i].fin);
    end

    // R5: all-ones steps to zero
    do_load({128{1'b1}});
    drain();
    run_batch(1, 40);
    cycle();
    chk("R5 all-ones wraps to zero", ciph_req_blk, '0);

    // R7: stalled cipher fills the store
    rsp_stall = 1'b1;
    cnt = 0;
    in_valid = 1'b1;
    for (int k = 0; k < 12; k++) begin
      in_data = {64'(k), 64'hABCD_0000_1234_5678};
      cycle();
      if (last_in) cnt++;
    end
    chk("R7 accepted blocks while stalled", 128'(cnt), 128'(DEPTH));
    #1;
    chk("R7 in_ready low when full", 128'(in_ready), 128'h0);
    in_valid = 1'b0;
    rsp_stall = 1'b0;
    drain();
    chk("R9 R7 counter after full burst", ciph_req_blk, 128'(DEPTH));

    // R8: load during an active stream
    rsp_stall = 1'b1;
    slow = 1'b1;
    cnt = 0;
    in_valid = 1'b1;
    while (cnt < 3) begin
      in_data = {96'h0, 32'(cnt + 77)};
      cycle();
      if (last_in) cnt++;
    end
    in_valid = 1'b0;
    held = ciph_req_blk;
    do_load(128'h5555_0000_0000_0000_0000_0000_0000_0100);
    #1;
    chk("R8 load_ready low while pending", 128'(load_ready), 128'h0);
    cnt = 0;
    in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      in_data = {96'h1, 32'(k)};
      cycle();
      if (last_in) cnt++;
    end
    chk("R8 no block accepted while load pending", 128'(cnt), 128'h0);
    chk("R8 counter unchanged before drain", ciph_req_blk, held);
    in_valid = 1'b0;
    rsp_stall = 1'b0;
    drain();
    slow = 1'b0;
    chk("R8 loaded value after drain", ciph_req_blk,
        128'h5555_0000_0000_0000_0000_0000_0000_0100);
    run_batch(2, 90);
    cycle();
    chk("R9 R8 counter after post-load batch", ciph_req_blk,
        128'h5555_0000_0000_0000_0000_0000_0000_0102);

    // R6 under cipher request stalls and output backpressure
    req_stall = 1'b0;
    do_load(128'h0000_0000_0000_0001_FFFF_FFFF_FFFF_FFFD);
    drain();
    run_batch(8, 123);
    cycle();
    chk("R9 R4 counter after long batch", ciph_req_blk,
        128'h0000_0000_0000_0002_0000_0000_0000_0005);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule